// File: doc/BRIEF.md
# Switch Priority Digit Display Driver

This block turns a small bank of slide switches into a single seven-segment digit. It finds the highest-numbered switch that is on and shows that switch's index (0 to 3) on the digit. The block is purely combinational: there is no clock and no storage, so the digit follows the switches directly.

A priority encoder turns the switches into a binary index and a valid flag. The index picks one of four fixed glyphs through a chain of 2-to-1 multiplexers. Each stage in the chain replaces the running result with the next glyph only when its own decoded select line is high. When no switch is on, every segment is driven off.

Top module: `sw_digit_disp`

## Requirements
- R1: When sw_i[3] is 1, seg_n_o is 7'b0110000 (digit 3), whatever sw_i[2:0] are set to.
- R2: When sw_i[3] is 0 and sw_i[2] is 1, seg_n_o is 7'b0100100 (digit 2), whatever sw_i[1:0] are set to.
- R3: When sw_i[3:2] is 2'b00 and sw_i[1] is 1, seg_n_o is 7'b1111001 (digit 1), whatever sw_i[0] is set to.
- R4: When sw_i is 4'b0001, seg_n_o is 7'b1000000 (digit 0).
- R5: When sw_i is 4'b0000, seg_n_o is 7'b1111111, so all segments are dark.
- R6: valid_o is 1 exactly when at least one bit of sw_i is 1.
- R7: Segments are active-low, with seg_n_o[0] driving segment a and seg_n_o[6] driving segment g. Outputs follow a change on sw_i with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw_i | input | 4 | Slide switch levels; bit n is switch n, and a higher index wins |
| seg_n_o | output | 7 | Active-low segment drives, bit 0 = a through bit 6 = g |
| valid_o | output | 1 | High when at least one switch is on |

## Verification
The bench applies all sixteen switch combinations. This covers the cases where a lower switch is on together with a higher one. A design with the priority reversed would then show the lowest index instead of the highest. A design with a mis-decoded stage select would show the glyph of a neighbouring stage: for example, a code of 00 would leak pattern B, or code 11 would stop at pattern C. The all-off case catches a design that shows digit 0, or holds valid high, when no switch is on. The single-switch patterns expose a glyph with swapped segment order or inverted polarity.

// File: rtl/swdisp_pkg.sv
// Package: shared widths, segment type and glyph function for the switch
// digit display. Assumes active-low segments, bit 0 = a .. bit 6 = g.
package swdisp_pkg;

    localparam int SEG_W = 7;

    typedef logic [SEG_W-1:0] seg_t;

    // All segments dark (active-low).
    localparam seg_t SEG_BLANK = '1;

    // Return the active-low glyph for a decimal digit; unknown digits go dark.
    function automatic seg_t digit_glyph(input int unsigned d);
        seg_t g;
        case (d)
            0: g = 7'b1000000;
            1: g = 7'b1111001;
            2: g = 7'b0100100;
            3: g = 7'b0110000;
            4: g = 7'b0011001;
            5: g = 7'b0010010;
            6: g = 7'b0000010;
            7: g = 7'b1111000;
            default: g = SEG_BLANK;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/swdisp_prio_enc.sv
// Module: priority encoder. Reports the index of the highest set request bit
// and whether any bit is set. Assumes NSW >= 2; with no bit set, the index is 0.
module swdisp_prio_enc #(
    parameter int NSW    = 4,
    parameter int CODE_W = $clog2(NSW)
) (
    input  logic [NSW-1:0]    req_i,
    output logic [CODE_W-1:0] code_o,
    output logic              any_o
);

    // Scan upward so that a higher set bit overrides any lower one.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < NSW; i++) begin
            if (req_i[i]) begin
                code_o = CODE_W'(i);
            end
        end
    end

    // Flag that at least one request is present.
    always_comb begin
        any_o = |req_i;
    end

endmodule

// File: rtl/swdisp_mux2.sv
// Module: bitwise 2-to-1 multiplexer. Passes a_i when sel_i is 0 and b_i
// when sel_i is 1. Assumes sel_i is a known level.
module swdisp_mux2 #(
    parameter int W = 7
) (
    input  logic         sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    // Bit-by-bit and-or selection.
    always_comb begin
        y_o = ({W{~sel_i}} & a_i) | ({W{sel_i}} & b_i);
    end

endmodule

// File: rtl/swdisp_glyph_chain.sv
// Module: N-to-1 glyph selector built as a cascade of 2-to-1 stages. Stage k
// replaces the running glyph with glyph k when the code equals k, so code 0
// falls through to glyph 0. Assumes code_i < NSW.
module swdisp_glyph_chain
    import swdisp_pkg::*;
#(
    parameter int NSW    = 4,
    parameter int CODE_W = $clog2(NSW)
) (
    input  logic [CODE_W-1:0] code_i,
    output seg_t              glyph_o
);

    seg_t           chain [NSW];
    logic [NSW-1:0] stage_sel;

    assign chain[0]     = digit_glyph(0);
    assign stage_sel[0] = 1'b0;

    genvar k;
    generate
        for (k = 1; k < NSW; k++) begin : g_stage
            // Decode this stage's select: high only for its own code value.
            always_comb begin
                stage_sel[k] = (code_i == CODE_W'(k));
            end

            swdisp_mux2 #(.W(SEG_W)) u_mux (
                .sel_i (stage_sel[k]),
                .a_i   (chain[k-1]),
                .b_i   (digit_glyph(k)),
                .y_o   (chain[k])
            );
        end
    endgenerate

    assign glyph_o = chain[NSW-1];

endmodule

// File: rtl/sw_digit_disp.sv
// Module: switch priority digit display driver (top). Shows the index of the
// highest-numbered switch that is on; blanks the digit when none is on.
// Assumes static switch levels (no debouncing) and active-low segments.
module sw_digit_disp
    import swdisp_pkg::*;
#(
    parameter int NSW = 4
) (
    input  logic [3:0] sw_i,
    output logic [6:0] seg_n_o,
    output logic       valid_o
);

    localparam int CODE_W = $clog2(NSW);

    logic [CODE_W-1:0] enc_code;
    logic              enc_any;
    seg_t              glyph;

    swdisp_prio_enc #(.NSW(NSW), .CODE_W(CODE_W)) u_enc (
        .req_i  (sw_i),
        .code_o (enc_code),
        .any_o  (enc_any)
    );

    swdisp_glyph_chain #(.NSW(NSW), .CODE_W(CODE_W)) u_chain (
        .code_i  (enc_code),
        .glyph_o (glyph)
    );

    // Blank the digit when no switch is on.
    always_comb begin
        seg_n_o = enc_any ? glyph : SEG_BLANK;
        valid_o = enc_any;
    end

endmodule

// File: rtl/sw_digit_disp_chk.sv
// Module: assertion checker for the display driver, bound into the top.
// Compares the encoder code, valid flag and segment outputs against the switches.
module sw_digit_disp_chk
    import swdisp_pkg::*;
#(
    parameter int NSW    = 4,
    parameter int CODE_W = $clog2(NSW)
) (
    input logic [NSW-1:0]    sw_i,
    input logic [CODE_W-1:0] code_i,
    input logic [SEG_W-1:0]  seg_i,
    input logic              valid_i
);

    int unsigned top_on;

    // Find the highest switch that is on, for the checks below.
    always_comb begin
        top_on = 0;
        for (int i = 0; i < NSW; i++) begin
            if (sw_i[i]) top_on = i;
        end
    end

    // Immediate checks of encoder against switches, and of outputs against encoder.
    always_comb begin
        if (valid_i) begin
            p_code_highest_r1: assert (int'(code_i) == top_on)
                else $error("encoder code is not the highest switch that is on");
            p_glyph_match_r2: assert (seg_i == digit_glyph(int'(code_i)))
                else $error("segments do not match the glyph for the code");
        end
        p_valid_any_r6: assert (valid_i == (|sw_i))
            else $error("valid disagrees with switches");
        if (!valid_i) begin
            p_blank_off_r5: assert (seg_i == SEG_BLANK)
                else $error("segments lit with no switch on");
        end
    end

endmodule

bind sw_digit_disp sw_digit_disp_chk #(.NSW(NSW), .CODE_W(CODE_W)) u_chk (
    .sw_i    (sw_i),
    .code_i  (enc_code),
    .seg_i   (seg_n_o),
    .valid_i (valid_o)
);

// File: tb/sw_digit_disp_bench.sv
// Bench: scoreboard for the display driver. A driver task applies switches on
// the rising edge and queues the expected outputs; a monitor pops and compares
// them on the falling edge.
module sw_digit_disp_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sw = 4'b0000;
    logic [6:0] seg_n;
    logic       valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] seg;
        logic       vld;
        logic [3:0] sw;
        string      tag;
    } exp_t;

    exp_t sb[$];

    sw_digit_disp u_sw_digit_disp (
        .sw_i    (sw),
        .seg_n_o (seg_n),
        .valid_o (valid)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Expected glyph from the requirements (active-low, bit 0 = a).
    function automatic logic [6:0] ref_glyph(input logic [3:0] s);
        if (s[3])      return 7'b0110000;
        else if (s[2]) return 7'b0100100;
        else if (s[1]) return 7'b1111001;
        else if (s[0]) return 7'b1000000;
        else           return 7'b1111111;
    endfunction

    // Pick the requirement a switch pattern exercises.
    function automatic string ref_tag(input logic [3:0] s);
        if (s[3])      return "R1";
        else if (s[2]) return "R2";
        else if (s[1]) return "R3";
        else if (s[0]) return "R4";
        else           return "R5";
    endfunction

    // Driver: apply a switch pattern and queue the expected result.
    task automatic drive(input logic [3:0] s);
        exp_t e;
        @(posedge clk);
        sw = s;
        e.seg = ref_glyph(s);
        e.vld = |s;
        e.sw  = s;
        e.tag = ref_tag(s);
        sb.push_back(e);
    endtask

    // Monitor: compare outputs against the scoreboard head away from the edge.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (seg_n !== e.seg) begin
                errors++;
                $display("FAIL %s/R7 sw=%b seg actual=%b expected=%b", e.tag, e.sw, seg_n, e.seg);
            end
            checks++;
            if (valid !== e.vld) begin
                errors++;
                $display("FAIL R6 sw=%b valid actual=%b expected=%b", e.sw, valid, e.vld);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus: reset-time check, then every switch combination.
    initial begin
        repeat (2) @(negedge clk);
        // R5 and R6: no switch on during reset, so the digit is dark and valid is low.
        checks++;
        if (seg_n !== 7'b1111111 || valid !== 1'b0) begin
            errors++;
            $display("FAIL R5 reset seg/valid actual=%b/%b expected=1111111/0", seg_n, valid);
        end
        @(posedge clk);
        rst_n = 1'b1;

        // R1..R5: sweep all sixteen combinations upward, then downward (R7 same-cycle follow).
        for (int v = 0; v < 16; v++) drive(4'(v));
        for (int v = 15; v >= 0; v--) drive(4'(v));
        // R1: sw3 with mixed lower switches; R3: sw1 toggling sw0.
        drive(4'b1001);
        drive(4'b0011);
        drive(4'b0010);
        drive(4'b0000);

        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule